// File: doc/BRIEF.md
# Two-Mode Page Table Walker

This block turns a 32-bit linear address into a physical address by walking in-memory translation tables, one entry at a time, through a simple request/response memory port. It offers two table formats, chosen per request by a mode input: a two-level format with 4-byte entries, and a three-level extended format with 8-byte entries that reaches physical addresses wider than 32 bits. Large pages are supported in both formats: 4 MB pages in the two-level format when large pages are enabled, and 2 MB pages in the extended format.

A request is a single-cycle pulse carrying the linear address, the table root and three mode bits (extended format, large-page enable, no-execute enable). The walker raises `busy_o` and issues one read per table level. When a non-leaf directory entry has its accessed flag clear, it writes that entry back with the flag set before going to the next level. It finishes with a one-cycle `done_o` pulse. The physical address, page size and combined permissions stay valid from that pulse until the next request completes. A walk ends early with a fault, and a reason code, when an entry is absent or has reserved bits set.

Top module: `ptw_walker`

## Requirements
- R1: During and after reset, `busy_o`, `done_o` and `mem_req_o` are low.
- R2: Two-level format (`pae_en_i`=0): the directory entry is read from byte address {root[31:12], va[31:22], 2'b00}. The table entry is read from {dir[31:12], va[21:12], 2'b00}. The result is {tbl[31:12], va[11:0]} with `page_size_o`=0 (4 KB).
- R3: Two-level format with `pse_en_i`=1: a directory entry with bit 7 set is a leaf. It yields the 40-bit address {dir[20:13], dir[31:22], va[21:0]} with `page_size_o`=2 (4 MB). With `pse_en_i`=0, bit 7 is ignored and the walk continues to the table level.
- R4: A two-level 4 MB leaf with bit 21 set ends with a reserved fault (`fault_code_o`=2).
- R5: Extended format (`pae_en_i`=1): the top entry is read from {root[31:5], va[31:30], 3'b000}. The directory entry is read from {top[PA_W-1:12], va[29:21], 3'b000}. The table entry is read from {dir[PA_W-1:12], va[20:12], 3'b000}. The result is {tbl[PA_W-1:12], va[11:0]} with `page_size_o`=0.
- R6: Extended format: a directory entry with bit 7 set is a 2 MB leaf. It yields {dir[PA_W-1:21], va[20:0]} with `page_size_o`=1. If any of its bits 20:13 is set, the walk ends with a reserved fault.
- R7: An entry with bit 0 clear ends the walk at once with `fault_o`=1 and `fault_code_o`=1 (absent). A completed walk has `fault_o`=0 and `fault_code_o`=0.
- R8: Extended format: entry bits 51:PA_W are reserved at every level, and bit 63 is reserved when `nx_en_i`=0. The top entry also treats bits 62:52 and bit 63 as reserved in every case. A reserved hit gives `fault_code_o`=2.
- R9: A non-leaf directory entry whose bit 5 is clear is written back to its own address with bit 5 set, before the next read. Entries with bit 5 set, top entries and leaves are never written.
- R10: `perm_o` bit 0 (writable) is the AND of bit 1 of the directory and table entries. Bit 1 (user) is the AND of their bit 2. Bit 2 (no-execute) is the OR of their bit 63, and only in the extended format. The top entry contributes nothing.
- R11: One walk at a time. `busy_o` is high from the cycle after acceptance until `done_o`. A request raised while busy is dropped. `mem_req_o` is high for one cycle, only while busy, and the next request waits for `mem_rvalid_i`.
- R12: `done_o` is a one-cycle pulse, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk (taken when idle) |
| req_vaddr_i | input | 32 | Linear address to translate |
| root_i | input | 32 | Table root value |
| pae_en_i | input | 1 | 1: three-level 8-byte format, 0: two-level 4-byte format |
| pse_en_i | input | 1 | Enables 4 MB leaves in the two-level format |
| nx_en_i | input | 1 | Enables entry bit 63 as no-execute |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | PA_W | Physical address |
| page_size_o | output | 2 | 0: 4 KB, 1: 2 MB, 2: 4 MB |
| perm_o | output | 3 | {no-execute, user, writable} |
| fault_o | output | 1 | Walk ended in a fault |
| fault_code_o | output | 2 | 0: none, 1: absent entry, 2: reserved bit |
| mem_req_o | output | 1 | Memory transaction strobe |
| mem_we_o | output | 1 | 1: write-back, 0: entry read |
| mem_addr_o | output | PA_W | Entry byte address |
| mem_wdata_o | output | 64 | Write-back data |
| mem_rvalid_i | input | 1 | Response (read data or write acknowledge) |
| mem_rdata_i | input | 64 | Entry read data (low 32 bits in two-level format) |

## Verification
The bench uses the default physical width PA_W=40. This width exactly fits the eight high address bits that a two-level 4 MB leaf supplies, so a 4 MB result above 4 GB can be checked bit for bit. It also leaves bits 51:40 of an extended entry as a reserved band that the bench can hit. A sparse memory model answers every transaction one cycle later and counts write-backs. This counting lets the bench confirm that the accessed-flag update happens on the first walk through a directory entry and not on a repeat walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int ENT_W  = 64;
  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_PS = 7;
  localparam int BIT_NX = 63;

  typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_4M = 2'd2} pg_size_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_ABSENT = 2'd1, FLT_RSVD = 2'd2} flt_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_RD_WAIT, ST_WB, ST_WB_WAIT} st_e;
endpackage

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
  import ptw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic [ENT_W-1:0] entry_i,
  input  logic             pae_i,
  input  logic             pse_i,
  input  logic             nxe_i,
  input  logic             top_i,
  input  logic             dir_i,
  output logic             present_o,
  output logic             large_o,
  output logic             rsvd_o
);
  localparam logic [ENT_W-1:0] HI_MASK   = ((64'd1 << 52) - 64'd1) & ~((64'd1 << PA_W) - 64'd1);
  localparam logic [ENT_W-1:0] USR_MASK  = 64'h7FF0_0000_0000_0000;
  localparam logic [ENT_W-1:0] NX_MASK   = 64'h8000_0000_0000_0000;
  localparam logic [ENT_W-1:0] LG2M_MASK = 64'h0000_0000_001F_E000;
  localparam logic [ENT_W-1:0] LG4M_MASK = 64'h0000_0000_0020_0000;

  logic [ENT_W-1:0] mask;

  assign present_o = entry_i[BIT_P];
  assign large_o   = dir_i & entry_i[BIT_PS] & (pae_i | pse_i);

  always_comb begin
    mask = '0;
    if (pae_i) begin
      mask = HI_MASK;
      if (!nxe_i) mask = mask | NX_MASK;
      if (top_i)  mask = mask | USR_MASK | NX_MASK;
      if (large_o) mask = mask | LG2M_MASK;
    end else if (large_o) begin
      mask = LG4M_MASK;
    end
  end

  assign rsvd_o = |(entry_i & mask);
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic [31:5]      root_i,
  input  logic [31:12]     va_i,
  input  logic             pae_i,
  input  logic [1:0]       lvl_i,
  input  logic [PA_W-1:12] prev_i,
  output logic [PA_W-1:0]  addr_o
);
  always_comb begin
    if (pae_i) begin
      case (lvl_i)
        2'd0:    addr_o = PA_W'({root_i[31:5], va_i[31:30], 3'b000});
        2'd1:    addr_o = {prev_i, va_i[29:21], 3'b000};
        default: addr_o = {prev_i, va_i[20:12], 3'b000};
      endcase
    end else begin
      if (lvl_i == 2'd0) addr_o = PA_W'({root_i[31:12], va_i[31:22], 2'b00});
      else               addr_o = PA_W'({prev_i[31:12], va_i[21:12], 2'b00});
    end
  end
endmodule

// File: rtl/ptw_leaf_pa.sv
module ptw_leaf_pa
  import ptw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic [PA_W-1:12] frame_i,
  input  logic [21:0]      va_i,
  input  logic             pae_i,
  input  logic             large_i,
  output logic [PA_W-1:0]  pa_o,
  output pg_size_e         size_o
);
  always_comb begin
    if (pae_i && large_i) begin
      pa_o   = {frame_i[PA_W-1:21], va_i[20:0]};
      size_o = PG_2M;
    end else if (pae_i) begin
      pa_o   = {frame_i, va_i[11:0]};
      size_o = PG_4K;
    end else if (large_i) begin
      // high address bits come from entry bits 20:13
      pa_o   = PA_W'({frame_i[20:13], frame_i[31:22], va_i[21:0]});
      size_o = PG_4M;
    end else begin
      pa_o   = PA_W'({frame_i[31:12], va_i[11:0]});
      size_o = PG_4K;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [31:0]      req_vaddr_i,
  input  logic [31:0]      root_i,
  input  logic             pae_en_i,
  input  logic             pse_en_i,
  input  logic             nx_en_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [1:0]       page_size_o,
  output logic [2:0]       perm_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [63:0]      mem_wdata_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i
);
  localparam logic [2:0] PERM_INIT = 3'b011;

  st_e              st_q;
  logic [1:0]       lvl_q;
  logic [VA_W-1:0]  va_q;
  logic [31:0]      root_q;
  logic             pae_q, pse_q, nxe_q;
  logic [ENT_W-1:0] prev_q, ent_q;
  logic [2:0]       acc_q;
  logic [PA_W-1:0]  pa_q;
  pg_size_e         size_q;
  logic [2:0]       perm_q;
  flt_e             flt_q;
  logic             done_q;

  logic [ENT_W-1:0] ent_w;
  logic             top_w, dir_w, last_w;
  logic             present_w, large_w, rsvd_w;
  logic [2:0]       acc_nx;
  logic [PA_W-1:0]  leaf_pa_w;
  pg_size_e         leaf_size_w;

  assign ent_w  = pae_q ? mem_rdata_i : {32'b0, mem_rdata_i[31:0]};
  assign top_w  = pae_q && (lvl_q == 2'd0);
  assign dir_w  = pae_q ? (lvl_q == 2'd1) : (lvl_q == 2'd0);
  assign last_w = pae_q ? (lvl_q == 2'd2) : (lvl_q == 2'd1);

  ptw_entry_chk #(.PA_W(PA_W)) u_chk_ent (
    .entry_i(ent_w), .pae_i(pae_q), .pse_i(pse_q), .nxe_i(nxe_q),
    .top_i(top_w), .dir_i(dir_w),
    .present_o(present_w), .large_o(large_w), .rsvd_o(rsvd_w)
  );

  ptw_addr_gen #(.PA_W(PA_W)) u_addr (
    .root_i(root_q[31:5]), .va_i(va_q[31:12]), .pae_i(pae_q), .lvl_i(lvl_q),
    .prev_i(prev_q[PA_W-1:12]), .addr_o(mem_addr_o)
  );

  ptw_leaf_pa #(.PA_W(PA_W)) u_leaf (
    .frame_i(ent_w[PA_W-1:12]), .va_i(va_q[21:0]), .pae_i(pae_q),
    .large_i(large_w), .pa_o(leaf_pa_w), .size_o(leaf_size_w)
  );

  // top-level entry of the extended format carries no permissions
  always_comb begin
    if (top_w) acc_nx = acc_q;
    else acc_nx = {acc_q[2] | (pae_q & ent_w[BIT_NX]),
                   acc_q[1] & ent_w[BIT_US],
                   acc_q[0] & ent_w[BIT_RW]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lvl_q  <= '0;
      va_q   <= '0;
      root_q <= '0;
      pae_q  <= 1'b0;
      pse_q  <= 1'b0;
      nxe_q  <= 1'b0;
      prev_q <= '0;
      ent_q  <= '0;
      acc_q  <= PERM_INIT;
      pa_q   <= '0;
      size_q <= PG_4K;
      perm_q <= '0;
      flt_q  <= FLT_NONE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q   <= req_vaddr_i;
            root_q <= root_i;
            pae_q  <= pae_en_i;
            pse_q  <= pse_en_i;
            nxe_q  <= nx_en_i;
            lvl_q  <= '0;
            acc_q  <= PERM_INIT;
            st_q   <= ST_RD;
          end
        end
        ST_RD: st_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_rvalid_i) begin
            if (!present_w || rsvd_w) begin
              flt_q  <= present_w ? FLT_RSVD : FLT_ABSENT;
              pa_q   <= '0;
              size_q <= PG_4K;
              perm_q <= '0;
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else if (last_w || large_w) begin
              flt_q  <= FLT_NONE;
              pa_q   <= leaf_pa_w;
              size_q <= leaf_size_w;
              perm_q <= acc_nx;
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              acc_q <= acc_nx;
              if (dir_w && !ent_w[BIT_A]) begin
                ent_q <= ent_w | (64'd1 << BIT_A);
                st_q  <= ST_WB;
              end else begin
                prev_q <= ent_w;
                lvl_q  <= lvl_q + 2'd1;
                st_q   <= ST_RD;
              end
            end
          end
        end
        ST_WB: st_q <= ST_WB_WAIT;
        ST_WB_WAIT: begin
          if (mem_rvalid_i) begin
            prev_q <= ent_q;
            lvl_q  <= lvl_q + 2'd1;
            st_q   <= ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign pa_o         = pa_q;
  assign page_size_o  = size_q;
  assign perm_o       = perm_q;
  assign fault_o      = (flt_q != FLT_NONE);
  assign fault_code_o = flt_q;
  assign mem_req_o    = (st_q == ST_RD) || (st_q == ST_WB);
  assign mem_we_o     = (st_q == ST_WB);
  assign mem_wdata_o  = ent_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        fault_o,
  input logic [1:0]  fault_code_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [63:0] mem_wdata_o
);
  assert_req_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_req_in_walk_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  assert_busy_ends_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_fault_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_o == (fault_code_o != 2'd0)));
  assert_wb_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[5] && mem_wdata_o[0]));
endmodule

bind ptw_walker ptw_walker_chk u_walker_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .fault_o(fault_o), .fault_code_o(fault_code_o), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  localparam int PA_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            req_valid = 1'b0;
  logic [31:0]     req_va = '0, root = '0;
  logic            pae = 1'b0, pse = 1'b0, nxe = 1'b0;
  logic            busy, done, fault, mreq, mwe;
  logic [PA_W-1:0] pa, maddr;
  logic [1:0]      psize, fcode;
  logic [2:0]      perm;
  logic [63:0]     mwdata;
  logic            mrvalid = 1'b0;
  logic [63:0]     mrdata = '0;

  ptw_walker #(.PA_W(PA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_va),
    .root_i(root), .pae_en_i(pae), .pse_en_i(pse), .nx_en_i(nxe),
    .busy_o(busy), .done_o(done), .pa_o(pa), .page_size_o(psize), .perm_o(perm),
    .fault_o(fault), .fault_code_o(fcode), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rvalid_i(mrvalid),
    .mem_rdata_i(mrdata)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // sparse entry memory, one-cycle response for reads and writes
  logic [63:0] tmem [logic [39:0]];
  int wr_cnt = 0;
  always @(posedge clk) begin
    mrvalid <= mreq;
    if (mreq) begin
      if (mwe) begin
        tmem[maddr] = mwdata;
        wr_cnt++;
        mrdata <= '0;
      end else begin
        mrdata <= tmem.exists(maddr) ? tmem[maddr] : 64'd0;
      end
    end
  end

  // scoreboard
  typedef struct {
    logic        flt;
    logic [1:0]  code;
    logic [39:0] pa;
    logic [1:0]  sz;
    logic [2:0]  perm;
    int          wr;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected completion", 64'(done), 64'd0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(fault == e.flt, {t, " fault"}, 64'(fault), 64'(e.flt));
        chk(fcode == e.code, {t, " R7 code"}, 64'(fcode), 64'(e.code));
        if (!e.flt) begin
          chk(pa == e.pa, {t, " pa"}, 64'(pa), 64'(e.pa));
          chk(psize == e.sz, {t, " size"}, 64'(psize), 64'(e.sz));
          chk(perm == e.perm, {t, " R10 perm"}, 64'(perm), 64'(e.perm));
        end
        chk(wr_cnt == e.wr, {t, " R9 writebacks"}, 64'(wr_cnt), 64'(e.wr));
        wr_cnt = 0;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] rt, input bit pa_m,
                      input bit ps_m, input bit nx_m, input bit ef, input logic [1:0] ec,
                      input logic [39:0] epa, input logic [1:0] esz, input logic [2:0] eperm,
                      input int ewr, input string tag, input bit poke_busy);
    exp_t e;
    e.flt = ef; e.code = ec; e.pa = epa; e.sz = esz; e.perm = eperm; e.wr = ewr;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_va = va; root = rt; pae = pa_m; pse = ps_m; nxe = nx_m; req_valid = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R11 busy after accept", 64'(busy), 64'd1);
    if (poke_busy) begin
      req_va = 32'h0100_0000; // would fault absent if taken
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    chk(done == 1'b0, "R12 done single cycle", 64'(done), 64'd0);
    chk(busy == 1'b0, "R11 idle after done", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // two-level tables, root 0x1000
    tmem[40'h1004]      = 64'h0000_2007;
    tmem[40'h200C]      = 64'h0005_5003;
    tmem[40'h1008]      = 64'h300B_40A7;
    tmem[40'h300B_4004] = 64'h0007_7007;
    tmem[40'h100C]      = 64'h0020_00A3;
    // extended tables, root 0x8000
    tmem[40'h8008] = 64'h0000_0000_0000_9001;
    tmem[40'h9018] = 64'h0000_0000_0000_A007;
    tmem[40'hA028] = 64'h8000_0000_0012_3005;
    tmem[40'h9020] = 64'h0000_0001_2340_00A3;
    tmem[40'h9028] = 64'h0000_0000_0060_20A1;
    tmem[40'h8010] = 64'h8000_0000_0000_9001;
    tmem[40'hA038] = 64'h0000_2000_0000_7001;

    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", 64'(busy), 64'd0);
    chk(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
    chk(mreq == 1'b0, "R1 mem_req in reset", 64'(mreq), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && mreq == 1'b0, "R1 idle after reset", 64'({busy, mreq}), 64'd0);

    walk(32'h0040_3ABC, 32'h1000, 0, 0, 0, 0, 2'd0, 40'h5_5ABC, 2'd0, 3'b001, 1, "R2 R9 legacy 4K first", 0);
    chk(tmem[40'h1004] == 64'h0000_2027, "R9 accessed flag written", tmem[40'h1004], 64'h2027);
    walk(32'h0040_3ABC, 32'h1000, 0, 0, 0, 0, 2'd0, 40'h5_5ABC, 2'd0, 3'b001, 0, "R2 R9 legacy 4K repeat", 0);
    walk(32'h0080_1234, 32'h1000, 0, 1, 0, 0, 2'd0, 40'h5A_3000_1234, 2'd2, 3'b011, 0, "R3 legacy 4M", 0);
    walk(32'h0080_1234, 32'h1000, 0, 0, 0, 0, 2'd0, 40'h7_7234, 2'd0, 3'b011, 0, "R3 size bit ignored", 0);
    walk(32'h00C0_0000, 32'h1000, 0, 1, 0, 1, 2'd2, 40'h0, 2'd0, 3'b000, 0, "R4 bit21 reserved", 0);
    walk(32'h0100_0000, 32'h1000, 0, 0, 0, 1, 2'd1, 40'h0, 2'd0, 3'b000, 0, "R7 legacy absent", 0);
    walk(32'h4060_5123, 32'h8000, 1, 0, 1, 0, 2'd0, 40'h12_3123, 2'd0, 3'b110, 1, "R5 R10 extended 4K", 0);
    chk(tmem[40'h9018] == 64'h0000_A027, "R9 extended dir flag", tmem[40'h9018], 64'hA027);
    walk(32'h4060_5123, 32'h8000, 1, 0, 0, 1, 2'd2, 40'h0, 2'd0, 3'b000, 0, "R8 bit63 without nx", 0);
    walk(32'h4080_0456, 32'h8000, 1, 0, 1, 0, 2'd0, 40'h1_2340_0456, 2'd1, 3'b001, 0, "R6 extended 2M", 0);
    walk(32'h40A0_0000, 32'h8000, 1, 0, 1, 1, 2'd2, 40'h0, 2'd0, 3'b000, 0, "R6 2M low bits reserved", 0);
    walk(32'h8000_0000, 32'h8000, 1, 0, 1, 1, 2'd2, 40'h0, 2'd0, 3'b000, 0, "R8 top entry bit63", 0);
    walk(32'h4060_6000, 32'h8000, 1, 0, 1, 1, 2'd1, 40'h0, 2'd0, 3'b000, 0, "R7 extended absent", 0);
    walk(32'h4060_7000, 32'h8000, 1, 0, 1, 1, 2'd2, 40'h0, 2'd0, 3'b000, 0, "R8 high band reserved", 0);
    walk(32'h0040_3ABC, 32'h1000, 0, 0, 0, 0, 2'd0, 40'h5_5ABC, 2'd0, 3'b001, 0, "R11 request while busy", 1);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0 && busy == 1'b0, "R11 dropped request", 64'(busy), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule